// File: doc/BRIEF.md
# PCM/TDM Serial Audio Port

This block is the master end of a four-wire PCM audio link. It divides the system clock to make the bit clock and emits one frame-sync pulse per frame. It sends audio on a transmit line and samples a receive line. A frame is a run of time slots. Each slot is a programmable number of bits, sent MSB first. Several devices can share the same wires by each taking its own slots, and two masks pick which slots this port drives and which it listens to.

There are two sync timings. In the early-sync timing, sync is high for the bit period just before the first MSB of the frame. In the aligned timing, sync rises together with that MSB. Transmit data changes on the falling bit-clock edge and receive data is sampled on the rising edge. In slots this port does not own, the transmit line is released and an output enable shows it.

On the host side, the port pulses `tx_load` with a slot index in the cycle before a transmit slot starts and takes the sample word in that cycle. Each received slot word is delivered as a one-cycle pulse on `rx_valid` together with its slot index.

Top module: `pcm_tdm_port`

## Requirements
- R1: `pcm_bclk` is low after reset and toggles every `BCLK_HALF` system clocks. `pcm_sync`, `pcm_tx_d` and `pcm_tx_oe` change only together with a falling `pcm_bclk` edge.
- R2: A frame is `cfg_slot_bits` × `cfg_slot_count` bit periods long, and `pcm_sync` is high for exactly one bit period per frame.
- R3: With `cfg_mode`=1 (aligned timing), `pcm_sync` is high during the bit period that carries the MSB of slot 0.
- R4: With `cfg_mode`=0 (early timing), `pcm_sync` is high during the bit period before the MSB of slot 0, which is the last bit of the previous frame. The first bit period after reset carries only sync, with `pcm_tx_oe` low.
- R5: A transmit slot sends the low `cfg_slot_bits` bits of the `tx_data` value present in the cycle where `tx_load` is high, MSB first, one bit per bit period. `tx_slot` gives the slot number, counting from 0 at the first slot after sync.
- R6: Bit k of `cfg_tx_mask` enables slot k. In an enabled slot `pcm_tx_oe` is high for every bit. Otherwise `pcm_tx_oe` is low, `pcm_tx_d` is 0 and no `tx_load` occurs.
- R7: `pcm_rx` is sampled on the rising `pcm_bclk` edge, and only in slots whose `cfg_rx_mask` bit is set. One system clock after the LSB is sampled, `rx_valid` pulses for one cycle with `rx_slot` and `rx_data`. `rx_data` is right-justified and zero above the slot width. Slots not in the mask produce nothing.
- R8: During reset, `pcm_bclk`, `pcm_sync`, `pcm_tx_d`, `pcm_tx_oe`, `tx_load` and `rx_valid` are all 0.
- R9: Slot widths from 8 to 32 bits and slot counts from 1 to 8 work, including both extremes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 1 | Sync timing: 0 early, 1 aligned |
| cfg_slot_bits | input | 6 | Bits per slot (8..32) |
| cfg_slot_count | input | 4 | Slots per frame (1..8) |
| cfg_tx_mask | input | 8 | Slots this port transmits |
| cfg_rx_mask | input | 8 | Slots this port receives |
| tx_data | input | 32 | Word for the slot named by tx_slot |
| tx_load | output | 1 | Word taken from tx_data this cycle |
| tx_slot | output | 3 | Slot being loaded |
| rx_valid | output | 1 | Received word pulse |
| rx_slot | output | 3 | Slot of the received word |
| rx_data | output | 32 | Received word, right-justified |
| pcm_bclk | output | 1 | Bit clock |
| pcm_sync | output | 1 | Frame sync |
| pcm_tx_d | output | 1 | Transmit data |
| pcm_tx_oe | output | 1 | Transmit line drive enable |
| pcm_rx | input | 1 | Receive data |

## Verification
The assertions assume that the configuration inputs stay inside the legal width and count ranges and do not change while reset is released. The bench keeps to this by setting a new configuration only while reset is held, and by drawing its random widths, counts and masks from the legal ranges. It also assumes `pcm_rx` is stable around each rising bit-clock edge. The bench drives `pcm_rx` only just after falling edges, and it drives random noise in slots the port does not own, so that the receive mask is exercised.

// File: rtl/pcm_tdm_pkg.sv
package pcm_tdm_pkg;
   typedef enum logic {
      FRAME_EARLY   = 1'b0,
      FRAME_ALIGNED = 1'b1
   } frame_mode_e;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_PRE  = 2'd1,
      SEQ_RUN  = 2'd2
   } seq_state_e;
endpackage

// File: rtl/pcm_bclk_gen.sv
module pcm_bclk_gen #(
   parameter int BCLK_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic bclk,
   output logic rise_evt,
   output logic fall_evt
);
   logic tick;

   generate
      if (BCLK_HALF == 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_count
         localparam int PW = $clog2(BCLK_HALF);
         localparam logic [PW-1:0] PH_LAST = PW'(BCLK_HALF - 1);
         logic [PW-1:0] ph_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ph_q <= '0;
            else if (ph_q == PH_LAST) ph_q <= '0;
            else ph_q <= ph_q + 1'b1;
         end
         assign tick = (ph_q == PH_LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk <= 1'b0;
      else if (tick) bclk <= ~bclk;
   end

   assign rise_evt = tick & ~bclk;
   assign fall_evt = tick & bclk;
endmodule

// File: rtl/pcm_slot_seq.sv
module pcm_slot_seq
   import pcm_tdm_pkg::*;
#(
   parameter int MAX_W     = 32,
   parameter int MAX_SLOTS = 8,
   localparam int CW = $clog2(MAX_W + 1),
   localparam int NW = $clog2(MAX_SLOTS + 1),
   localparam int BW = $clog2(MAX_W),
   localparam int SW = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fall_evt,
   input  logic          cfg_mode,
   input  logic [CW-1:0] cfg_slot_bits,
   input  logic [NW-1:0] cfg_slot_count,
   output logic          cur_active,
   output logic [BW-1:0] cur_bit,
   output logic [SW-1:0] cur_slot,
   output logic          nxt_active,
   output logic [BW-1:0] nxt_bit,
   output logic [SW-1:0] nxt_slot,
   output logic          sync_q
);
   seq_state_e st_q, st_n;
   logic [BW-1:0] last_bit;
   logic [SW-1:0] last_slot;
   logic          nxt_sync;

   assign last_bit  = BW'(cfg_slot_bits - 1'b1);
   assign last_slot = SW'(cfg_slot_count - 1'b1);

   always_comb begin
      st_n     = st_q;
      nxt_bit  = '0;
      nxt_slot = '0;
      unique case (st_q)
         SEQ_IDLE: st_n = (frame_mode_e'(cfg_mode) == FRAME_EARLY) ? SEQ_PRE : SEQ_RUN;
         SEQ_PRE:  st_n = SEQ_RUN;
         default: begin
            st_n = SEQ_RUN;
            if (cur_bit == last_bit) begin
               nxt_bit  = '0;
               nxt_slot = (cur_slot == last_slot) ? '0 : cur_slot + 1'b1;
            end else begin
               nxt_bit  = cur_bit + 1'b1;
               nxt_slot = cur_slot;
            end
         end
      endcase
   end

   assign nxt_active = (st_n == SEQ_RUN);

   always_comb begin
      if (frame_mode_e'(cfg_mode) == FRAME_ALIGNED)
         nxt_sync = nxt_active && (nxt_bit == '0) && (nxt_slot == '0);
      else
         nxt_sync = (st_n == SEQ_PRE) ||
                    (nxt_active && (nxt_bit == last_bit) && (nxt_slot == last_slot));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= SEQ_IDLE;
         cur_bit  <= '0;
         cur_slot <= '0;
         sync_q   <= 1'b0;
      end else if (fall_evt) begin
         st_q     <= st_n;
         cur_bit  <= nxt_bit;
         cur_slot <= nxt_slot;
         sync_q   <= nxt_sync;
      end
   end

   assign cur_active = (st_q == SEQ_RUN);
endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift #(
   parameter int MAX_W     = 32,
   parameter int MAX_SLOTS = 8,
   localparam int CW = $clog2(MAX_W + 1),
   localparam int BW = $clog2(MAX_W),
   localparam int SW = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fall_evt,
   input  logic                 nxt_active,
   input  logic [BW-1:0]        nxt_bit,
   input  logic [SW-1:0]        nxt_slot,
   input  logic [CW-1:0]        cfg_slot_bits,
   input  logic [MAX_SLOTS-1:0] cfg_tx_mask,
   input  logic [MAX_W-1:0]     tx_data,
   output logic                 tx_load,
   output logic                 pcm_tx_d,
   output logic                 pcm_tx_oe
);
   logic [MAX_W-1:0] sr_q;
   logic [MAX_W-1:0] aligned;
   logic             own_next;

   assign own_next = nxt_active && cfg_tx_mask[nxt_slot];
   assign tx_load  = fall_evt && own_next && (nxt_bit == '0);
   assign aligned  = tx_data << (MAX_W - int'(cfg_slot_bits));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q      <= '0;
         pcm_tx_d  <= 1'b0;
         pcm_tx_oe <= 1'b0;
      end else if (fall_evt) begin
         pcm_tx_oe <= own_next;
         if (tx_load) begin
            pcm_tx_d <= aligned[MAX_W-1];
            sr_q     <= aligned << 1;
         end else if (own_next) begin
            pcm_tx_d <= sr_q[MAX_W-1];
            sr_q     <= sr_q << 1;
         end else begin
            pcm_tx_d <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift #(
   parameter int MAX_W     = 32,
   parameter int MAX_SLOTS = 8,
   localparam int CW = $clog2(MAX_W + 1),
   localparam int BW = $clog2(MAX_W),
   localparam int SW = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rise_evt,
   input  logic                 cur_active,
   input  logic [BW-1:0]        cur_bit,
   input  logic [SW-1:0]        cur_slot,
   input  logic [CW-1:0]        cfg_slot_bits,
   input  logic [MAX_SLOTS-1:0] cfg_rx_mask,
   input  logic                 pcm_rx,
   output logic                 rx_valid,
   output logic [SW-1:0]        rx_slot,
   output logic [MAX_W-1:0]     rx_data
);
   logic [MAX_W-1:0] sr_q;
   logic [MAX_W-1:0] word_n;
   logic [MAX_W-1:0] keep;
   logic             take;
   logic             last;

   assign take   = rise_evt && cur_active && cfg_rx_mask[cur_slot];
   assign last   = (cur_bit == BW'(cfg_slot_bits - 1'b1));
   assign word_n = {sr_q[MAX_W-2:0], pcm_rx};
   assign keep   = ~({MAX_W{1'b1}} << cfg_slot_bits);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q     <= '0;
         rx_valid <= 1'b0;
         rx_slot  <= '0;
         rx_data  <= '0;
      end else begin
         rx_valid <= 1'b0;
         if (take) begin
            sr_q <= word_n;
            if (last) begin
               rx_valid <= 1'b1;
               rx_slot  <= cur_slot;
               rx_data  <= word_n & keep;
            end
         end
      end
   end
endmodule

// File: rtl/pcm_tdm_port.sv
module pcm_tdm_port #(
   parameter int MAX_W     = 32,
   parameter int MIN_W     = 8,
   parameter int MAX_SLOTS = 8,
   parameter int BCLK_HALF = 2,
   localparam int CW = $clog2(MAX_W + 1),
   localparam int NW = $clog2(MAX_SLOTS + 1),
   localparam int SW = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_mode,
   input  logic [CW-1:0]        cfg_slot_bits,
   input  logic [NW-1:0]        cfg_slot_count,
   input  logic [MAX_SLOTS-1:0] cfg_tx_mask,
   input  logic [MAX_SLOTS-1:0] cfg_rx_mask,
   input  logic [MAX_W-1:0]     tx_data,
   output logic                 tx_load,
   output logic [SW-1:0]        tx_slot,
   output logic                 rx_valid,
   output logic [SW-1:0]        rx_slot,
   output logic [MAX_W-1:0]     rx_data,
   output logic                 pcm_bclk,
   output logic                 pcm_sync,
   output logic                 pcm_tx_d,
   output logic                 pcm_tx_oe,
   input  logic                 pcm_rx
);
   localparam int BW = $clog2(MAX_W);

   initial begin
      assert (MIN_W >= 2 && MAX_W >= MIN_W) else $error("slot width range is empty");
      assert (MAX_SLOTS >= 1) else $error("at least one slot is needed");
      assert (BCLK_HALF >= 1) else $error("bit clock half period must be positive");
   end

   logic          rise_evt, fall_evt;
   logic          cur_active, nxt_active;
   logic [BW-1:0] cur_bit, nxt_bit;
   logic [SW-1:0] cur_slot, nxt_slot;

   pcm_bclk_gen #(.BCLK_HALF(BCLK_HALF)) u_bclk (
      .clk(clk), .rst_n(rst_n), .bclk(pcm_bclk),
      .rise_evt(rise_evt), .fall_evt(fall_evt)
   );

   pcm_slot_seq #(.MAX_W(MAX_W), .MAX_SLOTS(MAX_SLOTS)) u_seq (
      .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt),
      .cfg_mode(cfg_mode), .cfg_slot_bits(cfg_slot_bits),
      .cfg_slot_count(cfg_slot_count),
      .cur_active(cur_active), .cur_bit(cur_bit), .cur_slot(cur_slot),
      .nxt_active(nxt_active), .nxt_bit(nxt_bit), .nxt_slot(nxt_slot),
      .sync_q(pcm_sync)
   );

   pcm_tx_shift #(.MAX_W(MAX_W), .MAX_SLOTS(MAX_SLOTS)) u_tx (
      .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt),
      .nxt_active(nxt_active), .nxt_bit(nxt_bit), .nxt_slot(nxt_slot),
      .cfg_slot_bits(cfg_slot_bits), .cfg_tx_mask(cfg_tx_mask),
      .tx_data(tx_data), .tx_load(tx_load),
      .pcm_tx_d(pcm_tx_d), .pcm_tx_oe(pcm_tx_oe)
   );

   assign tx_slot = nxt_slot;

   pcm_rx_shift #(.MAX_W(MAX_W), .MAX_SLOTS(MAX_SLOTS)) u_rx (
      .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt),
      .cur_active(cur_active), .cur_bit(cur_bit), .cur_slot(cur_slot),
      .cfg_slot_bits(cfg_slot_bits), .cfg_rx_mask(cfg_rx_mask),
      .pcm_rx(pcm_rx), .rx_valid(rx_valid), .rx_slot(rx_slot), .rx_data(rx_data)
   );
endmodule

// File: rtl/pcm_tdm_port_chk.sv
module pcm_tdm_port_chk #(
   parameter int MAX_W     = 32,
   parameter int MIN_W     = 8,
   parameter int MAX_SLOTS = 8,
   localparam int CW = $clog2(MAX_W + 1),
   localparam int NW = $clog2(MAX_SLOTS + 1),
   localparam int SW = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 rise_evt,
   input logic                 fall_evt,
   input logic [CW-1:0]        cfg_slot_bits,
   input logic [NW-1:0]        cfg_slot_count,
   input logic [MAX_SLOTS-1:0] cfg_tx_mask,
   input logic [MAX_SLOTS-1:0] cfg_rx_mask,
   input logic                 tx_load,
   input logic [SW-1:0]        tx_slot,
   input logic                 rx_valid,
   input logic [SW-1:0]        rx_slot,
   input logic [MAX_W-1:0]     rx_data,
   input logic                 pcm_bclk,
   input logic                 pcm_sync,
   input logic                 pcm_tx_d,
   input logic                 pcm_tx_oe
);
   // R9
   cfg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cfg_slot_bits) >= MIN_W) && (int'(cfg_slot_bits) <= MAX_W) &&
      (cfg_slot_count != '0) && (int'(cfg_slot_count) <= MAX_SLOTS));

   // R1
   bclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rise_evt && !fall_evt) |=> $stable(pcm_bclk));

   // R1
   line_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fall_evt |=> ($stable(pcm_sync) && $stable(pcm_tx_d) && $stable(pcm_tx_oe)));

   // R2
   sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_evt && pcm_sync) |=> !pcm_sync);

   // R6
   tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pcm_tx_oe |-> !pcm_tx_d);

   // R6
   tx_load_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |-> (cfg_tx_mask[tx_slot] && fall_evt));

   // R7
   rx_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> cfg_rx_mask[rx_slot]);

   // R7
   rx_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> ((rx_data & ({MAX_W{1'b1}} << cfg_slot_bits)) == '0));

   // R7
   rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R7
   rx_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_valid) |-> $past(rise_evt));
endmodule

bind pcm_tdm_port pcm_tdm_port_chk #(
   .MAX_W(MAX_W), .MIN_W(MIN_W), .MAX_SLOTS(MAX_SLOTS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .fall_evt(fall_evt),
   .cfg_slot_bits(cfg_slot_bits), .cfg_slot_count(cfg_slot_count),
   .cfg_tx_mask(cfg_tx_mask), .cfg_rx_mask(cfg_rx_mask),
   .tx_load(tx_load), .tx_slot(tx_slot),
   .rx_valid(rx_valid), .rx_slot(rx_slot), .rx_data(rx_data),
   .pcm_bclk(pcm_bclk), .pcm_sync(pcm_sync),
   .pcm_tx_d(pcm_tx_d), .pcm_tx_oe(pcm_tx_oe)
);

// File: tb/pcm_tdm_port_bench.sv
`timescale 1ns/100ps
module pcm_tdm_port_bench;
   localparam int HALF = 2;
   localparam real TCLK = 5.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_mode = 1'b0;
   logic [5:0]  cfg_slot_bits = 6'd8;
   logic [3:0]  cfg_slot_count = 4'd1;
   logic [7:0]  cfg_tx_mask = '0;
   logic [7:0]  cfg_rx_mask = '0;
   logic [31:0] tx_data;
   logic        tx_load;
   logic [2:0]  tx_slot;
   logic        rx_valid;
   logic [2:0]  rx_slot;
   logic [31:0] rx_data;
   logic        pcm_bclk, pcm_sync, pcm_tx_d, pcm_tx_oe;
   logic        pcm_rx = 1'b0;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int tx_seq = 0;
   bit finished = 0;

   int          exp_slot [0:511];
   logic [31:0] exp_word [0:511];
   int          wr_ix = 0;
   int          rd_ix = 0;
   bit          rx_mon_en = 0;

   always #(TCLK/2) clk = ~clk;

   function automatic logic [31:0] gen_word(input int k, input int s, input int salt);
      logic [31:0] h;
      h = 32'(k) * 32'h9E37_79B1;
      h = h ^ (32'(s) << 20) ^ (32'(salt) * 32'h85EB_CA6B) ^ 32'hA5C3_5A3C;
      h = h ^ (h >> 13);
      return h;
   endfunction

   function automatic logic [31:0] width_mask(input int w);
      return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
   endfunction

   assign tx_data = gen_word(tx_seq, int'(tx_slot), 1);

   always @(posedge clk) begin
      if (!rst_n) tx_seq <= 0;
      else if (tx_load) tx_seq <= tx_seq + 1;
   end

   pcm_tdm_port #(.BCLK_HALF(HALF)) u_pcm_tdm_port (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
      .cfg_slot_bits(cfg_slot_bits), .cfg_slot_count(cfg_slot_count),
      .cfg_tx_mask(cfg_tx_mask), .cfg_rx_mask(cfg_rx_mask),
      .tx_data(tx_data), .tx_load(tx_load), .tx_slot(tx_slot),
      .rx_valid(rx_valid), .rx_slot(rx_slot), .rx_data(rx_data),
      .pcm_bclk(pcm_bclk), .pcm_sync(pcm_sync),
      .pcm_tx_d(pcm_tx_d), .pcm_tx_oe(pcm_tx_oe), .pcm_rx(pcm_rx)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // R7: received words checked in order
   always @(negedge clk) begin
      if (rx_mon_en && rx_valid) begin
         if (rd_ix < wr_ix) begin
            chk(int'(rx_slot) == exp_slot[rd_ix], "R7 rx_slot", 32'(rx_slot), 32'(exp_slot[rd_ix]));
            chk(rx_data == exp_word[rd_ix], "R7 rx_data", rx_data, exp_word[rd_ix]);
            rd_ix++;
         end else begin
            chk(1'b0, "R7 unexpected rx_valid", 32'(rx_slot), 32'hFFFF_FFFF);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog R1 actual=%0d expected<190000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic run_cfg(input bit mode, input int w, input int n,
                          input logic [7:0] txm, input logic [7:0] rxm, input int frames);
      int len, pos, done, tx_nth, rx_nth, slot, bitn;
      bit locked, skip;
      realtime last_rise;
      logic [31:0] cur_tx, cur_rx, m;
      rst_n = 1'b0;
      rx_mon_en = 0;
      pcm_rx = 1'b0;
      cfg_mode = mode;
      cfg_slot_bits = 6'(w);
      cfg_slot_count = 4'(n);
      cfg_tx_mask = txm & 8'((1 << n) - 1);
      cfg_rx_mask = rxm & 8'((1 << n) - 1);
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R8: outputs quiet in reset
      chk({pcm_bclk, pcm_sync, pcm_tx_d, pcm_tx_oe, tx_load, rx_valid} == 6'b0,
          "R8 reset outputs", 32'({pcm_bclk, pcm_sync, pcm_tx_d, pcm_tx_oe, tx_load, rx_valid}), 32'h0);
      wr_ix = 0;
      rd_ix = 0;
      rx_mon_en = 1;
      rst_n = 1'b1;
      len = w * n;
      m = width_mask(w);
      pos = 0; done = 0; tx_nth = 0; rx_nth = 0;
      locked = 0; skip = 0; last_rise = 0;
      cur_tx = '0; cur_rx = '0;
      while (done < frames) begin
         @(negedge pcm_bclk);
         #1;
         if (!locked) begin
            if (pcm_sync) begin
               locked = 1;
               skip = !mode;
               pos = mode ? 0 : len - 1;
            end
         end else begin
            skip = 0;
            pos = (pos + 1) % len;
         end
         slot = pos / w;
         bitn = pos % w;
         if (locked && !skip && cfg_rx_mask[slot]) begin
            if (bitn == 0) begin
               cur_rx = gen_word(rx_nth, slot, 2) & m;
               rx_nth++;
            end
            pcm_rx = cur_rx[w - 1 - bitn];
         end else begin
            pcm_rx = 1'($urandom);
         end
         @(posedge pcm_bclk);
         if (last_rise != 0)
            chk(($realtime - last_rise) == 2 * HALF * TCLK, "R1 bclk period",
                32'(int'($realtime - last_rise)), 32'(int'(2 * HALF * TCLK)));
         last_rise = $realtime;
         if (!locked) continue;
         if (skip) begin
            // R4: leading sync-only bit
            chk(pcm_sync && !pcm_tx_oe, "R4 lead-in bit", 32'({pcm_sync, pcm_tx_oe}), 32'b10);
            continue;
         end
         if (mode)
            chk(pcm_sync == (pos == 0), "R3 aligned sync", 32'(pcm_sync), 32'(pos == 0));
         else
            chk(pcm_sync == (pos == len - 1), "R4 early sync", 32'(pcm_sync), 32'(pos == len - 1));
         chk(pcm_tx_oe == cfg_tx_mask[slot], "R6 tx enable", 32'(pcm_tx_oe), 32'(cfg_tx_mask[slot]));
         if (cfg_tx_mask[slot]) begin
            if (bitn == 0) begin
               cur_tx = gen_word(tx_nth, slot, 1) & m;
               tx_nth++;
            end
            chk(pcm_tx_d == cur_tx[w - 1 - bitn], "R5 tx bit", 32'(pcm_tx_d), 32'(cur_tx[w - 1 - bitn]));
         end else begin
            chk(pcm_tx_d == 1'b0, "R6 idle tx line", 32'(pcm_tx_d), 32'h0);
         end
         if (cfg_rx_mask[slot] && bitn == w - 1) begin
            exp_slot[wr_ix] = slot;
            exp_word[wr_ix] = cur_rx;
            wr_ix++;
         end
         if (pos == len - 1) done++;
      end
      repeat (8) @(posedge clk);
      @(negedge clk);
      // R2 frame count and R7 delivered count
      chk(rd_ix == wr_ix, "R7 rx word count", 32'(rd_ix), 32'(wr_ix));
      chk(done == frames, "R2 frames seen", 32'(done), 32'(frames));
      rx_mon_en = 0;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      // R9 smallest slot and single slot, early timing
      run_cfg(1'b0, 8, 1, 8'h01, 8'h01, 4);
      // R9 widest slot and most slots, aligned timing
      run_cfg(1'b1, 32, 8, 8'hFF, 8'hFF, 3);
      // R6 R7 nothing owned: line released, nothing received
      run_cfg(1'b1, 16, 4, 8'h00, 8'h00, 3);
      // R6 R7 disjoint sparse masks
      run_cfg(1'b0, 24, 3, 8'h05, 8'h02, 3);
      run_cfg(1'b1, 8, 8, 8'hAA, 8'h55, 3);
      for (int i = 0; i < 7; i++) begin
         run_cfg(1'($urandom), 8 + int'($urandom % 25), 1 + int'($urandom % 8),
                 8'($urandom), 8'($urandom), 3);
      end
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule